// File: doc/BRIEF.md
# Burst Offset Sequencer

This block supplies the lowest address bits of a synchronous SRAM word address while a burst is in progress. When a new access starts, it captures a starting offset from the low address inputs. Each later advance cycle moves it to the next beat of a four-beat burst, and after the last beat it wraps back to the starting offset.

Beats can follow one of two orders. In linear order the offset counts up and wraps around. In interleaved order the offset is the starting value XOR the beat index. A static order-select input picks the order; the board ties it high or low. A clock-enable input suspends the sequencer, and while it is low every register holds. The offset leaves the block from a register, so it can go straight to an array address decoder.

The offset width is the parameter `OFF_W`, with a default of 2, which gives four beats.

Top module: `burst_addr_seq`

## Requirements
- R1: A cycle with `rst` high at the clock edge sets `burst_off` to 0 and sets the beat index to 0 from the following cycle on.
- R2: With `clk_en` high and `load_sel` high at an edge, `burst_off` equals the `start_off` sampled at that edge, and that value becomes the burst's starting offset.
- R3: With `clk_en` high, `load_sel` low and `order_il` low (linear), `burst_off` becomes the previous `burst_off` plus one, modulo 4. For example, a start of 2 gives 2,3,0,1.
- R4: With `clk_en` high, `load_sel` low and `order_il` high (interleaved), `burst_off` becomes the starting offset XOR the new beat index (0..3). For example, a start of 1 gives 1,0,3,2.
- R5: Four consecutive advances after a load bring `burst_off` back to the starting offset, in either order.
- R6: With `clk_en` low at an edge, `burst_off` and the beat position hold, and `load_sel` and `start_off` have no effect. The next enabled advance continues from the held position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; low suspends the sequencer |
| load_sel | input | 1 | 1 = load a new start offset, 0 = advance one beat |
| start_off | input | OFF_W (2) | Low address bits that seed the burst |
| order_il | input | 1 | Static order select: 0 = linear, 1 = interleaved |
| burst_off | output | OFF_W (2) | Registered current burst offset |

## Verification
On every cycle, the assertions check the reset value, the load capture, the one-step moves in linear and interleaved order, the hold while suspended, and that the output equals the starting offset whenever the beat index is zero. The bench scenarios are what show complete burst orders from each starting offset. They also show the wrap over long runs of advances, and that a suspended cycle carrying a load with a different start value leaves the burst untouched and the next advance resumes from where it stopped.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_STEP  = 2'd2,
    ACT_RESET = 2'd3
  } seq_act_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  seq_act_e         act,
  output logic [OFF_W-1:0] beat_q,
  output logic [OFF_W-1:0] beat_nxt
);
  localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

  always_comb begin
    unique case (act)
      ACT_RESET: beat_nxt = '0;
      ACT_LOAD:  beat_nxt = '0;
      ACT_STEP:  beat_nxt = beat_q + ONE;
      default:   beat_nxt = beat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    beat_q <= beat_nxt;
  end

  // R6: a suspended cycle leaves the beat index alone
  a_r6_beat_hold: assert property (@(posedge clk)
    disable iff (act == ACT_RESET)
    act == ACT_HOLD |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] start,
  input  logic [OFF_W-1:0] beat,
  input  order_e           order,
  output logic [OFF_W-1:0] off
);
  logic [OFF_W-1:0] lin_off;
  logic [OFF_W-1:0] il_off;

  assign lin_off = start + beat;

  for (genvar i = 0; i < OFF_W; i++) begin : g_xor
    assign il_off[i] = start[i] ^ beat[i];
  end

  assign off = (order == ORD_INTERLEAVE) ? il_off : lin_off;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             load_sel,
  input  logic [OFF_W-1:0] start_off,
  input  logic             order_il,
  output logic [OFF_W-1:0] burst_off
);
  seq_act_e         act;
  logic [OFF_W-1:0] start_q;
  logic [OFF_W-1:0] beat_q;
  logic [OFF_W-1:0] beat_nxt;
  logic [OFF_W-1:0] step_off;
  order_e           order;

  assign order = order_e'(order_il);

  always_comb begin
    if (rst)           act = ACT_RESET;
    else if (!clk_en)  act = ACT_HOLD;
    else if (load_sel) act = ACT_LOAD;
    else               act = ACT_STEP;
  end

  burst_beat_ctr #(.OFF_W(OFF_W)) u_beat (
    .clk      (clk),
    .act      (act),
    .beat_q   (beat_q),
    .beat_nxt (beat_nxt)
  );

  burst_order_map #(.OFF_W(OFF_W)) u_map (
    .start (start_q),
    .beat  (beat_nxt),
    .order (order),
    .off   (step_off)
  );

  always_ff @(posedge clk) begin
    unique case (act)
      ACT_RESET: begin
        start_q   <= '0;
        burst_off <= '0;
      end
      ACT_LOAD: begin
        start_q   <= start_off;
        burst_off <= start_off;
      end
      ACT_STEP: begin
        burst_off <= step_off;
      end
      default: ;
    endcase
  end

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (burst_off == '0 && beat_q == '0));

  a_r2_load_capture: assert property (@(posedge clk) disable iff (rst)
    clk_en && load_sel |=> burst_off == $past(start_off));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
    clk_en && !load_sel && !order_il |=>
      burst_off == OFF_W'($past(burst_off) + 1'b1));

  a_r4_interleave_step: assert property (@(posedge clk) disable iff (rst)
    clk_en && !load_sel && order_il |=>
      burst_off == ($past(start_q) ^ OFF_W'($past(beat_q) + 1'b1)));

  a_r5_wrap_start: assert property (@(posedge clk) disable iff (rst)
    beat_q == '0 |-> burst_off == start_q);

  a_r6_suspend_hold: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(burst_off) && $stable(start_q)));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int OFF_W = 2;

  logic             clk = 1'b0;
  logic             rst;
  logic             clk_en;
  logic             load_sel;
  logic [OFF_W-1:0] start_off;
  logic             order_il;
  logic [OFF_W-1:0] burst_off;

  int n_tests = 0;
  int n_fail  = 0;
  logic [OFF_W-1:0] m_start;
  logic [OFF_W-1:0] m_beat;
  logic [OFF_W-1:0] m_exp;

  always #2 clk = ~clk;

  burst_addr_seq #(.OFF_W(OFF_W)) dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .load_sel(load_sel),
    .start_off(start_off), .order_il(order_il), .burst_off(burst_off)
  );

  function automatic logic [OFF_W-1:0] order_val(
      input logic [OFF_W-1:0] s, input logic [OFF_W-1:0] b, input logic il);
    return il ? (s ^ b) : OFF_W'(s + b);
  endfunction

  task automatic check(input string tag, input logic [OFF_W-1:0] exp);
    n_tests++;
    if (burst_off !== exp) begin
      n_fail++;
      $display("FAIL %s: burst_off=%0d expected %0d at %0t", tag, burst_off, exp, $time);
    end
  endtask

  // drive at negedge, model updates at posedge, check at the next negedge
  task automatic cyc(input logic r, input logic ce, input logic ld,
                     input logic [OFF_W-1:0] st, input logic il, input string tag);
    rst = r; clk_en = ce; load_sel = ld; start_off = st; order_il = il;
    @(posedge clk);
    if (r) begin
      m_start = '0; m_beat = '0; m_exp = '0;
    end else if (ce) begin
      if (ld) begin
        m_start = st; m_beat = '0;
      end else begin
        m_beat = m_beat + OFF_W'(1);
      end
      m_exp = order_val(m_start, m_beat, il);
    end
    #2;
    check(tag, m_exp);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; clk_en = 1'b0; load_sel = 1'b0; start_off = '0; order_il = 1'b0;
    m_start = '0; m_beat = '0; m_exp = '0;
    @(negedge clk);
    cyc(1'b1, 1'b0, 1'b0, 2'd3, 1'b0, "R1 reset");
    cyc(1'b1, 1'b1, 1'b1, 2'd2, 1'b1, "R1 reset beats load");

    // linear from 2: 2,3,0,1 then wrap to 2
    cyc(1'b0, 1'b1, 1'b1, 2'd2, 1'b0, "R2 load linear");
    cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R3 linear beat1");
    cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R3 linear beat2");
    cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R3 linear beat3");
    cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R5 linear wrap");
    if (burst_off !== 2'd2) begin n_fail++; $display("FAIL R5: actual %0d expected 2", burst_off); end
    n_tests++;

    // interleaved from 1: 1,0,3,2 then wrap to 1
    cyc(1'b0, 1'b1, 1'b1, 2'd1, 1'b1, "R2 load interleaved");
    cyc(1'b0, 1'b1, 1'b0, 2'd3, 1'b1, "R4 interleave beat1");
    cyc(1'b0, 1'b1, 1'b0, 2'd3, 1'b1, "R4 interleave beat2");
    cyc(1'b0, 1'b1, 1'b0, 2'd3, 1'b1, "R4 interleave beat3");
    cyc(1'b0, 1'b1, 1'b0, 2'd3, 1'b1, "R5 interleave wrap");

    // suspend with a competing load, then resume the burst
    cyc(1'b0, 1'b1, 1'b1, 2'd3, 1'b1, "R2 load 3");
    cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R4 step from 3");
    cyc(1'b0, 1'b0, 1'b1, 2'd0, 1'b1, "R6 suspended load ignored");
    cyc(1'b0, 1'b0, 1'b0, 2'd1, 1'b1, "R6 suspended advance ignored");
    cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R6 resume beat2");
    cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R4 resume beat3");

    // constrained random: order held per burst, changes only at loads
    for (int burst = 0; burst < 400; burst++) begin
      logic il;
      il = 1'($urandom);
      cyc(1'b0, 1'b1, 1'b1, OFF_W'($urandom), il, "R2 random load");
      for (int k = 0; k < 1 + int'($urandom % 9); k++) begin
        logic ce;
        ce = ($urandom % 4) != 0;
        cyc(1'b0, ce, ce ? 1'b0 : 1'($urandom), OFF_W'($urandom), il,
            ce ? (il ? "R4 random step" : "R3 random step") : "R6 random suspend");
      end
      if (($urandom % 50) == 0) cyc(1'b1, 1'($urandom), 1'($urandom), OFF_W'($urandom), il, "R1 random reset");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule